// File: doc/BRIEF.md
# Pipelined Eight-Key Bitonic Merger

This block merges two short ascending runs of unsigned keys into one ascending run of eight keys. Each input vector carries four keys, with lane 0 the smallest. Internally the second vector is read in reverse lane order, so the eight keys form a single rise-then-fall sequence. Three compare levels then sort that sequence. Each level applies a lane-wise minimum and maximum to all four lane pairs at once and writes them into separate low and high vectors. A fixed lane permutation ahead of each level brings the right partners together. A final interleave of the last low and high vectors gives the sorted result.

The block sits inside a merge-sort datapath. The caller presents one pair of sorted vectors on any cycle with the valid flag high. The block returns the four smallest keys on one output vector and the four largest on the other, with a fixed latency of three cycles and a new merge accepted on every cycle. The key width is a parameter (32 bits by default).

Top module: `bitonic_merge8`

## Requirements
- R1: When `out_valid` is high, the eight output keys are in non-decreasing order. The order runs from `out_lo` lane 0 to lane 3, then from `out_hi` lane 0 to lane 3, where lane i occupies bits [i*KEY_W +: KEY_W]. So `out_lo` holds the four smallest keys.
- R2: The eight output keys are exactly the eight input keys of the same merge, as a multiset.
- R3: A merge presented with `in_valid` high at a rising edge appears with `out_valid` high after the third rising edge, counting that one.
- R4: A new merge is accepted on every cycle. Back-to-back inputs yield back-to-back outputs in issue order.
- R5: Synchronous active-high `rst` discards every merge in flight. `out_valid` is low in the cycle after any reset edge and stays low until a fresh valid input has passed through.
- R6: Cycles with `in_valid` low produce no output, whatever values sit on `in_a` and `in_b`.
- R7: When every key of `in_b` is below every key of `in_a`, `out_lo` equals `in_b` and `out_hi` equals `in_a`. The mirrored case also holds.
- R8: Duplicate keys, up to all eight being equal, give a correctly sorted output.
- R9: Keys compare as unsigned numbers: the all-ones key sorts last and zero sorts first.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Marks a merge request on this cycle |
| in_a | input | 4*KEY_W | First ascending run, lane 0 in the low bits |
| in_b | input | 4*KEY_W | Second ascending run, lane 0 in the low bits |
| out_valid | output | 1 | Marks a merged result on this cycle |
| out_lo | output | 4*KEY_W | Four smallest keys, ascending from lane 0 |
| out_hi | output | 4*KEY_W | Four largest keys, ascending from lane 0 |

## Verification
A wrong lane route or a swapped min/max in any level corrupts the result on the first merge that exercises that lane pair. It shows either as an out-of-order pair across the eight outputs or as a key lost and another duplicated, three cycles after the input. Exact comparison against an independent sort of the eight keys exposes both. A fault in the valid chain shows as a result that arrives a cycle early or late, an idle cycle that yields an output, or a merge that survives reset. Each of these becomes visible within three cycles of the stimulus that triggers it.

// File: rtl/mrg_pkg.sv
`timescale 1ns/1ps
package mrg_pkg;

    localparam int LANES      = 4;
    localparam int LEVELS     = $clog2(2 * LANES);
    localparam int LANE_IDX_W = $clog2(LANES);

    typedef logic [LANE_IDX_W:0] lane_src_t;

    function automatic lane_src_t route_src(input int lvl, input bit y_side, input int lane);
        int src;
        bit from_h;
        case (lvl)
            1: begin
                from_h = y_side;
                src    = y_side ? (LANES - 1 - lane) : lane;
            end
            2: begin
                from_h = (lane >= LANES / 2);
                src    = (lane % (LANES / 2)) + (y_side ? LANES / 2 : 0);
            end
            default: begin
                from_h = (lane % 2) == 1;
                src    = (lane / 2) * 2 + (y_side ? 1 : 0);
            end
        endcase
        return {from_h, src[LANE_IDX_W-1:0]};
    endfunction

    function automatic lane_src_t final_src(input int pos);
        int src;
        bit from_h;
        from_h = (pos % 2) == 1;
        src    = pos / 2;
        return {from_h, src[LANE_IDX_W-1:0]};
    endfunction

endpackage

// File: rtl/mrg_minmax.sv
`timescale 1ns/1ps
module mrg_minmax
    import mrg_pkg::*;
#(
    parameter int KEY_W = 32
) (
    input  logic [LANES-1:0][KEY_W-1:0] x,
    input  logic [LANES-1:0][KEY_W-1:0] y,
    output logic [LANES-1:0][KEY_W-1:0] lo,
    output logic [LANES-1:0][KEY_W-1:0] hi
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic y_smaller;
        assign y_smaller = (y[j] < x[j]);
        assign lo[j]     = y_smaller ? y[j] : x[j];
        assign hi[j]     = y_smaller ? x[j] : y[j];
    end

endmodule

// File: rtl/mrg_route.sv
`timescale 1ns/1ps
module mrg_route
    import mrg_pkg::*;
#(
    parameter int KEY_W = 32,
    parameter int LVL   = 1
) (
    input  logic [LANES-1:0][KEY_W-1:0] l,
    input  logic [LANES-1:0][KEY_W-1:0] h,
    output logic [LANES-1:0][KEY_W-1:0] x,
    output logic [LANES-1:0][KEY_W-1:0] y
);

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        localparam lane_src_t SX = route_src(LVL, 1'b0, j);
        localparam lane_src_t SY = route_src(LVL, 1'b1, j);
        assign x[j] = SX[LANE_IDX_W] ? h[SX[LANE_IDX_W-1:0]] : l[SX[LANE_IDX_W-1:0]];
        assign y[j] = SY[LANE_IDX_W] ? h[SY[LANE_IDX_W-1:0]] : l[SY[LANE_IDX_W-1:0]];
    end

endmodule

// File: rtl/mrg_level.sv
`timescale 1ns/1ps
module mrg_level
    import mrg_pkg::*;
#(
    parameter int KEY_W = 32,
    parameter int LVL   = 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_vld,
    input  logic [LANES-1:0][KEY_W-1:0] in_l,
    input  logic [LANES-1:0][KEY_W-1:0] in_h,
    output logic                        out_vld,
    output logic [LANES-1:0][KEY_W-1:0] out_l,
    output logic [LANES-1:0][KEY_W-1:0] out_h
);

    logic [LANES-1:0][KEY_W-1:0] px, py, mn, mx;

    mrg_route #(.KEY_W(KEY_W), .LVL(LVL)) u_route (
        .l (in_l),
        .h (in_h),
        .x (px),
        .y (py)
    );

    mrg_minmax #(.KEY_W(KEY_W)) u_cmp (
        .x  (px),
        .y  (py),
        .lo (mn),
        .hi (mx)
    );

    always_ff @(posedge clk) begin
        if (rst) out_vld <= 1'b0;
        else     out_vld <= in_vld;
    end

    always_ff @(posedge clk) begin
        if (in_vld) begin
            out_l <= mn;
            out_h <= mx;
        end
    end

endmodule

// File: rtl/bitonic_merge8.sv
`timescale 1ns/1ps
module bitonic_merge8
    import mrg_pkg::*;
#(
    parameter int KEY_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [LANES*KEY_W-1:0] in_a,
    input  logic [LANES*KEY_W-1:0] in_b,
    output logic                   out_valid,
    output logic [LANES*KEY_W-1:0] out_lo,
    output logic [LANES*KEY_W-1:0] out_hi
);

    logic [LEVELS:0]             vld;
    logic [LANES-1:0][KEY_W-1:0] lv [0:LEVELS];
    logic [LANES-1:0][KEY_W-1:0] hv [0:LEVELS];
    logic [2*LANES-1:0][KEY_W-1:0] merged;

    // level 1 treats in_a as its low source and in_b as its high source
    assign vld[0] = in_valid;
    assign lv[0]  = in_a;
    assign hv[0]  = in_b;

    for (genvar g = 1; g <= LEVELS; g++) begin : g_level
        mrg_level #(.KEY_W(KEY_W), .LVL(g)) u_level (
            .clk     (clk),
            .rst     (rst),
            .in_vld  (vld[g-1]),
            .in_l    (lv[g-1]),
            .in_h    (hv[g-1]),
            .out_vld (vld[g]),
            .out_l   (lv[g]),
            .out_h   (hv[g])
        );
    end

    for (genvar p = 0; p < 2 * LANES; p++) begin : g_weave
        localparam lane_src_t S = final_src(p);
        assign merged[p] = S[LANE_IDX_W] ? hv[LEVELS][S[LANE_IDX_W-1:0]]
                                         : lv[LEVELS][S[LANE_IDX_W-1:0]];
    end

    assign out_valid = vld[LEVELS];
    assign out_lo    = merged[LANES-1:0];
    assign out_hi    = merged[2*LANES-1:LANES];

endmodule

// File: rtl/mrg_chk.sv
`timescale 1ns/1ps
module mrg_chk
    import mrg_pkg::*;
#(
    parameter int KEY_W = 32
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_valid,
    input logic [LANES*KEY_W-1:0] in_a,
    input logic [LANES*KEY_W-1:0] in_b,
    input logic                   out_valid,
    input logic [LANES*KEY_W-1:0] out_lo,
    input logic [LANES*KEY_W-1:0] out_hi
);

    localparam int SUM_W = KEY_W + $clog2(2 * LANES) + 1;

    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)             age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    function automatic logic [SUM_W-1:0] key_sum(input logic [2*LANES*KEY_W-1:0] v);
        logic [SUM_W-1:0] s;
        s = '0;
        for (int k = 0; k < 2 * LANES; k++) s = s + SUM_W'(v[k*KEY_W +: KEY_W]);
        return s;
    endfunction

    function automatic logic is_sorted(input logic [2*LANES*KEY_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int k = 1; k < 2 * LANES; k++)
            if (v[k*KEY_W +: KEY_W] < v[(k-1)*KEY_W +: KEY_W]) ok = 1'b0;
        return ok;
    endfunction

    // R1
    sort_order_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> is_sorted({out_hi, out_lo}));

    // R2
    key_sum_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && out_valid) |-> key_sum({out_hi, out_lo}) == $past(key_sum({in_b, in_a}), 3));

    // R3
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && $past(in_valid, 3)) |-> out_valid);

    // R5
    rst_flush_chk: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (age == 2'd3 && !$past(in_valid, 3)) |-> !out_valid);

endmodule

bind bitonic_merge8 mrg_chk #(.KEY_W(KEY_W)) u_mrg_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_lo    (out_lo),
    .out_hi    (out_hi)
);

// File: tb/tb_bitonic_merge8.sv
`timescale 1ns/1ps
module tb_bitonic_merge8;

    localparam int KW = 32;
    localparam int VW = 4 * KW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_a = '0;
    logic [VW-1:0] in_b = '0;
    logic          out_valid;
    logic [VW-1:0] out_lo;
    logic [VW-1:0] out_hi;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int recv = 0;
    bit done = 1'b0;

    logic [2*VW-1:0] exp_q[$];
    int              t_q[$];

    bitonic_merge8 #(.KEY_W(KW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_lo(out_lo), .out_hi(out_hi)
    );

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [2*VW-1:0] act,
                         input logic [2*VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] pack4(input logic [KW-1:0] k0, k1, k2, k3);
        return {k3, k2, k1, k0};
    endfunction

    function automatic logic [2*VW-1:0] ref_sort(input logic [VW-1:0] a, input logic [VW-1:0] b);
        logic [KW-1:0] k [8];
        logic [KW-1:0] t;
        logic [2*VW-1:0] r;
        for (int i = 0; i < 4; i++) begin
            k[i]   = a[i*KW +: KW];
            k[i+4] = b[i*KW +: KW];
        end
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 7 - i; j++)
                if (k[j+1] < k[j]) begin t = k[j]; k[j] = k[j+1]; k[j+1] = t; end
        for (int i = 0; i < 8; i++) r[i*KW +: KW] = k[i];
        return r;
    endfunction

    function automatic logic [VW-1:0] rand_run(input logic [KW-1:0] mask);
        logic [KW-1:0] k [4];
        logic [KW-1:0] t;
        for (int i = 0; i < 4; i++) k[i] = $urandom() & mask;
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 3 - i; j++)
                if (k[j+1] < k[j]) begin t = k[j]; k[j] = k[j+1]; k[j+1] = t; end
        return pack4(k[0], k[1], k[2], k[3]);
    endfunction

    // output monitor: content (R1, R2) and latency (R3) of every result
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            recv++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 output with no pending merge", {out_hi, out_lo}, '0);
            end else begin
                logic [2*VW-1:0] e;
                int t0;
                e  = exp_q.pop_front();
                t0 = t_q.pop_front();
                check({out_hi, out_lo} == e, "R1 R2 merged keys", {out_hi, out_lo}, e);
                check(cyc - t0 == 3, "R3 latency", (2*VW)'(cyc - t0), (2*VW)'(3));
            end
        end
    end

    task automatic drive(input bit v, input logic [VW-1:0] a, input logic [VW-1:0] b);
        @(negedge clk);
        in_valid = v;
        in_a     = a;
        in_b     = b;
        if (v) begin
            exp_q.push_back(ref_sort(a, b));
            t_q.push_back(cyc);
        end
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R4 all merges delivered", (2*VW)'(exp_q.size()), '0);
    endtask

    task automatic t_reset();
        in_valid = 1'b1;
        in_a = pack4(1, 2, 3, 4);
        in_b = pack4(5, 6, 7, 8);
        repeat (4) @(negedge clk);
        check(out_valid == 1'b0, "R5 out_valid low in reset", (2*VW)'(out_valid), '0);
        rst = 1'b0;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(recv == 0, "R5 nothing after reset release", (2*VW)'(recv), '0);
    endtask

    task automatic t_basic();
        int r0;
        r0 = recv;
        drive(1, pack4(1, 3, 5, 7), pack4(2, 4, 6, 8));     // R1 interleaved runs
        drive(1, pack4(10, 11, 40, 41), pack4(20, 21, 22, 50));
        drive(1, pack4(5, 100, 200, 300), pack4(6, 7, 8, 9));
        drain();
        check(recv - r0 == 3, "R1 result count", (2*VW)'(recv - r0), (2*VW)'(3));
    endtask

    task automatic t_disjoint();
        // R7 one run entirely below the other
        drive(1, pack4(100, 101, 102, 103), pack4(1, 2, 3, 4));
        drive(1, pack4(1, 2, 3, 4), pack4(100, 101, 102, 103));
        drive(1'b0, '0, '0);
        @(negedge clk);
        check(out_valid && out_lo == pack4(1, 2, 3, 4) && out_hi == pack4(100, 101, 102, 103),
              "R7 low run in_b", {out_hi, out_lo}, {pack4(100, 101, 102, 103), pack4(1, 2, 3, 4)});
        drain();
    endtask

    task automatic t_dups();
        // R8 repeated keys
        drive(1, pack4(7, 7, 7, 7), pack4(7, 7, 7, 7));
        drive(1, pack4(3, 3, 9, 9), pack4(3, 9, 9, 9));
        drive(1, pack4(0, 5, 5, 6), pack4(5, 5, 5, 5));
        drain();
    endtask

    task automatic t_extremes();
        // R9 unsigned compare at the ends of the range
        drive(1, pack4(0, 0, 32'h8000_0000, 32'hFFFF_FFFF), pack4(1, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF));
        drive(1'b0, '0, '0);
        drive(1'b0, '0, '0);
        @(negedge clk);
        check(out_valid && out_hi[3*KW +: KW] == 32'hFFFF_FFFF && out_lo[0 +: KW] == 32'd0,
              "R9 unsigned ends", {out_hi, out_lo}, ref_sort(pack4(0, 0, 32'h8000_0000, 32'hFFFF_FFFF),
              pack4(1, 32'h7FFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFF)));
        drain();
    endtask

    task automatic t_stream();
        // R4 back-to-back merges, narrow range mixes in duplicates
        int r0;
        r0 = recv;
        for (int i = 0; i < 60; i++)
            drive(1, rand_run(i % 2 ? 32'hFFFF_FFFF : 32'h0000_000F),
                     rand_run(i % 3 ? 32'hFFFF_FFFF : 32'h0000_000F));
        drain();
        check(recv - r0 == 60, "R4 stream count", (2*VW)'(recv - r0), (2*VW)'(60));
    endtask

    task automatic t_gaps();
        // R6 idle cycles carry junk data that must not emerge
        int r0;
        r0 = recv;
        for (int i = 0; i < 20; i++) begin
            drive(1, rand_run(32'hFFFF_FFFF), rand_run(32'hFFFF_FFFF));
            drive(0, {VW{1'b1}}, '0);
            if (i % 3 == 0) drive(0, '0, {VW{1'b1}});
        end
        drain();
        check(recv - r0 == 20, "R6 only valid merges emerge", (2*VW)'(recv - r0), (2*VW)'(20));
    endtask

    task automatic t_reset_mid();
        // R5 merges in flight are discarded
        int r0;
        drive(1, pack4(1, 2, 3, 4), pack4(5, 6, 7, 8));
        drive(1, pack4(9, 9, 9, 9), pack4(1, 1, 1, 1));
        @(negedge clk);
        in_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_q.delete();
        t_q.delete();
        r0 = recv;
        repeat (5) @(negedge clk);
        check(recv == r0, "R5 flushed merges", (2*VW)'(recv - r0), '0);
        drive(1, pack4(2, 4, 6, 8), pack4(1, 3, 5, 7));
        drain();
        check(recv - r0 == 1, "R5 merge after reset", (2*VW)'(recv - r0), (2*VW)'(1));
    endtask

    initial begin
        t_reset();
        t_basic();
        t_disjoint();
        t_dups();
        t_extremes();
        t_stream();
        t_gaps();
        t_reset_mid();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog actual=%0d cycles expected=completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule